// File: doc/BRIEF.md
# Serial Slave Response Receiver

This block collects the reply of a slave device on a two-wire serial link made of a clock and one shared data line. After a command has gone out, the controller pulses `start_i` and gives the number of data bytes it expects. The receiver then releases the data line and generates one bus clock per bit. Each bit is sampled in the cycle that follows the rising bus-clock edge. The line is active low, so every sample is inverted before it is used.

The receiver first hunts for a start bit and gives up after a bounded number of bus clocks. Once the start bit is found it reads a 4-bit header, which holds the slave address and the response tag. A data phase follows only when the tag is an acknowledge and the caller asked for data. A 4-bit check code closes the frame. The check is computed over an implied leading one, the header, the data and the check bits, and it must leave a zero remainder. The outcome goes out with a one-cycle done pulse: address, tag, data word, a timeout flag and a check-error flag. Retries and command transmission belong to other blocks.

Top module: `rsp_rx`

## Requirements
- R1: After reset the receiver is idle: `busy_o`=0, `done_o`=0, `bus_clk_o`=1, `data_oe_o`=1, and all result outputs are 0.
- R2: `start_i` seen while idle begins a reception on the next cycle. Each bit takes two cycles: `bus_clk_o` low, then high. The logical bit is the inverse of `data_i`, sampled at the clock edge that ends the high cycle.
- R3: The start bit is the first logical 1. If `TIMEOUT_CLKS` bits are sampled without one, the reception ends with `timeout_o`=1 and all other result fields 0. A start bit found on sample number `TIMEOUT_CLKS` is accepted.
- R4: After the start bit, 4 header bits arrive MSB first. Bits 3:2 go to `slave_id_o` and bits 1:0 go to `tag_o`. Tag 0 means acknowledge, 1 busy, 2 general error and 3 check error seen by the slave.
- R5: `size_i` codes 0, 1, 2 and 3 request 0, 1, 2 and 4 data bytes. The data bits (8 per byte) are read only when the tag is 0 and the code is nonzero. Otherwise the check bits follow the header directly.
- R6: `data_o` holds the data bits right-aligned, with the first received bit as the MSB, so the first byte is the most significant. It is 0 when there is no data phase.
- R7: The check uses polynomial x^4+x+1, MSB first, with initial value 0. It runs over a leading 1, the header, the data and the 4 received check bits. A nonzero remainder sets `crc_err_o`.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last sample, and `busy_o` is low in that cycle. The result outputs hold until the next reception ends.
- R9: `start_i` and changes on `size_i` have no effect while a reception is in progress.
- R10: `data_oe_o` is 0 for the whole reception and 1 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a reception (honoured only when idle) |
| size_i | input | 2 | Expected data size code |
| data_i | input | 1 | Serial data line, active low |
| bus_clk_o | output | 1 | Generated bus clock, idles high |
| data_oe_o | output | 1 | Data line drive enable, low while receiving |
| busy_o | output | 1 | Reception in progress |
| done_o | output | 1 | One-cycle result strobe |
| slave_id_o | output | 2 | Responding slave address |
| tag_o | output | 2 | Response tag |
| data_o | output | 32 | Received data word |
| timeout_o | output | 1 | No start bit within the limit |
| crc_err_o | output | 1 | Nonzero check remainder |

## Verification
The hardest case to reach is the timeout boundary. A start bit on the very last allowed sample must be accepted, and one sample later the reception must time out. The bench reaches it by placing exactly `TIMEOUT_CLKS`-1 idle bits ahead of the frame, and in a separate run by sending no start bit at all. A second hard case is a busy or error tag combined with a nonzero size request. There the data phase must be skipped, and the bench catches this through the per-cycle bus-clock and done timing. Start requests and size changes are also injected mid-frame to show they are ignored.

// File: rtl/rsp_rx_pkg.sv
package rsp_rx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HDR_W  = 4;
  localparam int unsigned CHK_W  = 4;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);
  localparam logic [CHK_W-1:0] CHK_POLY = 4'h3;
  localparam logic [1:0] TAG_ACK = 2'd0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_HDR,
    ST_DATA,
    ST_CHK
  } rx_state_e;

  typedef struct packed {
    logic [1:0]        id;
    logic [1:0]        tag;
    logic [DATA_W-1:0] data;
    logic              tmo;
    logic              chk_err;
  } rx_result_t;

  function automatic logic [CNT_W-1:0] size_bits(input logic [1:0] code);
    case (code)
      2'd0:    size_bits = CNT_W'(0);
      2'd1:    size_bits = CNT_W'(8);
      2'd2:    size_bits = CNT_W'(16);
      default: size_bits = CNT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/rsp_rx_clkgen.sv
module rsp_rx_clkgen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic bus_clk_o,
  output logic sample_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= 1'b0;
    else if (!run_i) ph_q <= 1'b0;
    else             ph_q <= ~ph_q;
  end

  // low phase first, sample at the edge closing the high phase
  assign bus_clk_o = ~(run_i & ~ph_q);
  assign sample_o  = run_i & ph_q;
endmodule

// File: rtl/rsp_rx_crc.sv
module rsp_rx_crc #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] POLY = 4'h3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o,
  output logic [W-1:0] crc_nxt_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb        = crc_q[W-1] ^ bit_i;
  assign crc_nxt_o = {crc_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
  assign crc_o     = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc_nxt_o;
  end
endmodule

// File: rtl/rsp_rx_shreg.sv
module rsp_rx_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (clr_i) q <= '0;
    else if (en_i)  q <= {q[W-2:0], bit_i};
  end

  assign q_o = q;
endmodule

// File: rtl/rsp_rx.sv
module rsp_rx
  import rsp_rx_pkg::*;
#(
  parameter int unsigned TIMEOUT_CLKS = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic              data_i,
  output logic              bus_clk_o,
  output logic              data_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        slave_id_o,
  output logic [1:0]        tag_o,
  output logic [DATA_W-1:0] data_o,
  output logic              timeout_o,
  output logic              crc_err_o
);
  localparam int unsigned HUNT_W = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [HUNT_W-1:0] HUNT_LAST = HUNT_W'(TIMEOUT_CLKS - 1);

  rx_state_e          st_q;
  logic [1:0]         size_q;
  logic [HUNT_W-1:0]  hunt_q;
  logic [CNT_W-1:0]   cnt_q;
  rx_result_t         res_q;
  logic               done_q;

  logic               run, accept, smp, bit_b;
  logic [CHK_W-1:0]   chk_q, chk_nxt;
  logic [HDR_W-1:0]   hdr_q;
  logic [DATA_W-1:0]  dat_q;
  logic [1:0]         tag_now;
  logic [CNT_W-1:0]   data_last;

  assign run     = (st_q != ST_IDLE);
  assign accept  = start_i & ~run;
  assign bit_b   = ~data_i;            // line is active low
  assign tag_now = {hdr_q[0], bit_b};
  assign data_last = size_bits(size_q) - CNT_W'(1);

  rsp_rx_clkgen u_clkgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .bus_clk_o(bus_clk_o),
    .sample_o (smp)
  );

  // start bit (a logical 1) seeds the check
  rsp_rx_crc #(.W(CHK_W), .POLY(CHK_POLY)) u_crc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .en_i     (smp & ((st_q != ST_HUNT) | bit_b)),
    .bit_i    (bit_b),
    .crc_o    (chk_q),
    .crc_nxt_o(chk_nxt)
  );

  rsp_rx_shreg #(.W(HDR_W)) u_hdr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .en_i  (smp & (st_q == ST_HDR)),
    .bit_i (bit_b),
    .q_o   (hdr_q)
  );

  rsp_rx_shreg #(.W(DATA_W)) u_data (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .en_i  (smp & (st_q == ST_DATA)),
    .bit_i (bit_b),
    .q_o   (dat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      size_q <= '0;
      hunt_q <= '0;
      cnt_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_HUNT;
            size_q <= size_i;
            hunt_q <= '0;
            cnt_q  <= '0;
          end
        end
        ST_HUNT: begin
          if (smp) begin
            if (bit_b) begin
              st_q  <= ST_HDR;
              cnt_q <= '0;
            end else if (hunt_q == HUNT_LAST) begin
              res_q     <= '0;
              res_q.tmo <= 1'b1;
              done_q    <= 1'b1;
              st_q      <= ST_IDLE;
            end else begin
              hunt_q <= hunt_q + HUNT_W'(1);
            end
          end
        end
        ST_HDR: begin
          if (smp) begin
            if (cnt_q == CNT_W'(HDR_W - 1)) begin
              cnt_q <= '0;
              st_q  <= ((tag_now == TAG_ACK) && (size_q != 2'd0)) ? ST_DATA : ST_CHK;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (smp) begin
            if (cnt_q == data_last) begin
              cnt_q <= '0;
              st_q  <= ST_CHK;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_CHK: begin
          if (smp) begin
            if (cnt_q == CNT_W'(CHK_W - 1)) begin
              res_q.id      <= hdr_q[3:2];
              res_q.tag     <= hdr_q[1:0];
              res_q.data    <= dat_q;
              res_q.tmo     <= 1'b0;
              res_q.chk_err <= (chk_nxt != '0);
              done_q        <= 1'b1;
              st_q          <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = run;
  assign data_oe_o  = ~run;
  assign done_o     = done_q;
  assign slave_id_o = res_q.id;
  assign tag_o      = res_q.tag;
  assign data_o     = res_q.data;
  assign timeout_o  = res_q.tmo;
  assign crc_err_o  = res_q.chk_err;

  logic unused_chk;
  assign unused_chk = ^chk_q;
endmodule

// File: rtl/rsp_rx_chk.sv
module rsp_rx_chk #(
  parameter int unsigned TIMEOUT_CLKS = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic bus_clk_o,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o,
  input logic crc_err_o
);
  localparam int unsigned MAX_BUSY = 2 * (TIMEOUT_CLKS + 4 + 32 + 4);
  localparam int unsigned BW = $clog2(MAX_BUSY + 2);

  logic [BW-1:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + BW'(1);
    else             busy_run <= '0;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R2
  clk_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bus_clk_o) |=> (busy_o && bus_clk_o));

  // R2
  first_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !bus_clk_o);

  // R2
  start_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  // R1
  idle_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> bus_clk_o);

  // R7
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(timeout_o && crc_err_o));

  // R3
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= BW'(MAX_BUSY));
endmodule

bind rsp_rx rsp_rx_chk #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .bus_clk_o(bus_clk_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .timeout_o(timeout_o),
  .crc_err_o(crc_err_o)
);

// File: tb/rsp_rx_test.sv
`timescale 1ns/1ps
module rsp_rx_test;
  localparam int TMO = 1000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic        data_i = 1'b1;
  logic        bus_clk_o, data_oe_o, busy_o, done_o, timeout_o, crc_err_o;
  logic [1:0]  slave_id_o, tag_o;
  logic [31:0] data_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  rsp_rx #(.TIMEOUT_CLKS(TMO)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .size_i(size_i),
    .data_i(data_i), .bus_clk_o(bus_clk_o), .data_oe_o(data_oe_o),
    .busy_o(busy_o), .done_o(done_o), .slave_id_o(slave_id_o), .tag_o(tag_o),
    .data_o(data_o), .timeout_o(timeout_o), .crc_err_o(crc_err_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int chk4(input int bits[$]);
    int c = 0;
    foreach (bits[i]) begin
      int fb = ((c >> 3) & 1) ^ bits[i];
      c = (c << 1) & 15;
      if (fb != 0) c = c ^ 3;
    end
    return c;
  endfunction

  // gap: idle bits before start; no_start: never send a start bit
  task automatic run_txn(input string req, input int gap, input int id, input int tag,
                         input int code, input logic [31:0] dat, input bit corrupt,
                         input bit no_start, input bit poke);
    int q[$];
    int msg[$];
    int nb, n, cyc_err, c;
    logic [31:0] exp_dat;
    bit has_data;
    nb = (code == 3) ? 4 : code;
    has_data = (tag == 0) && (nb > 0);
    exp_dat = 32'h0;
    for (int i = 0; i < gap; i++) q.push_back(0);
    if (!no_start) begin
      msg.push_back(1);
      msg.push_back((id >> 1) & 1); msg.push_back(id & 1);
      msg.push_back((tag >> 1) & 1); msg.push_back(tag & 1);
      if (has_data) begin
        for (int i = nb*8-1; i >= 0; i--) begin
          msg.push_back(int'(dat[i]));
          exp_dat = {exp_dat[30:0], dat[i]};
        end
      end
      c = chk4(msg);
      if (corrupt) c = c ^ 1;
      for (int i = 3; i >= 0; i--) msg.push_back((c >> i) & 1);
      foreach (msg[i]) q.push_back(msg[i]);
      n = q.size();
    end else begin
      n = TMO;
    end
    cyc_err = 0;
    @(negedge clk_i);
    size_i = 2'(code);
    start_i = 1'b1;
    for (int k = 1; k <= 2*n + 2; k++) begin
      @(negedge clk_i);
      if (k == 1) start_i = 1'b0;
      if (poke && k == 6) begin start_i = 1'b1; size_i = ~2'(code); end
      if (poke && k == 7) start_i = 1'b0;
      if (busy_o !== (k <= 2*n)) cyc_err++;
      if (bus_clk_o !== ((k <= 2*n) ? (k % 2 == 0) : 1'b1)) cyc_err++;
      if (data_oe_o !== (k > 2*n)) cyc_err++;
      if (done_o !== (k == 2*n + 1)) cyc_err++;
      if ((k % 2 == 1) && (k <= 2*n)) begin
        int idx = (k - 1) / 2;
        data_i = (idx < q.size()) ? ~1'(q[idx]) : 1'b1;
      end
      if (k == 2*n + 1) begin
        data_i = 1'b1;
        chk(req, "done", longint'(done_o), 1);
        chk(req, "timeout", longint'(timeout_o), longint'(no_start));
        chk(req, "crc_err", longint'(crc_err_o), longint'(corrupt && !no_start));
        chk(req, "slave_id", longint'(slave_id_o), no_start ? 0 : id);
        chk(req, "tag", longint'(tag_o), no_start ? 0 : tag);
        chk(req, "data", longint'(data_o), longint'(exp_dat));
      end
    end
    chk(req, "cycle timing mismatches", cyc_err, 0);
    // R8: result held after the strobe
    chk("R8", "held data", longint'(data_o), longint'(exp_dat));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "busy", longint'(busy_o), 0);
    chk("R1", "done", longint'(done_o), 0);
    chk("R1", "bus_clk", longint'(bus_clk_o), 1);
    chk("R1", "data_oe", longint'(data_oe_o), 1);
    chk("R1", "data", longint'(data_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R10", "idle oe", longint'(data_oe_o), 1);

    run_txn("R2 R4 ack no data", 3, 1, 0, 0, 32'h0, 0, 0, 0);
    run_txn("R5 R6 one byte", 1, 2, 0, 1, 32'hA5, 0, 0, 0);
    run_txn("R5 R6 two bytes", 5, 2, 0, 2, 32'h1234, 0, 0, 0);
    run_txn("R5 R6 four bytes", 0, 3, 0, 3, 32'hDEADBEEF, 0, 0, 0);
    run_txn("R5 busy tag skips data", 2, 1, 1, 3, 32'hFFFFFFFF, 0, 0, 0);
    run_txn("R4 error tag", 0, 0, 2, 2, 32'h5555, 0, 0, 0);
    run_txn("R4 slave check tag", 4, 3, 3, 1, 32'h77, 0, 0, 0);
    run_txn("R7 corrupted check", 1, 2, 0, 2, 32'hC3A9, 1, 0, 0);
    run_txn("R7 corrupted no data", 0, 0, 1, 0, 32'h0, 1, 0, 0);
    run_txn("R3 timeout", 0, 0, 0, 1, 32'h0, 0, 1, 0);
    run_txn("R3 start on last sample", TMO-1, 1, 0, 1, 32'h3C, 0, 0, 0);
    run_txn("R9 start ignored while busy", 2, 2, 0, 3, 32'h0F1E2D3C, 0, 0, 1);
    run_txn("R9 size change ignored", 0, 1, 0, 1, 32'h81, 0, 0, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule